// File: doc/BRIEF.md
# Handshake-Counted Delay Line

This block sits in a ready/valid stream and hands back every accepted item a fixed number of transfers later. The latency is a count of handshakes, not of clock cycles. Stalls on either side stretch the wall-clock time but never change which output transfer carries which input item. How many items happen to be in flight also has no effect on that pairing.

Items wait in a circular buffer held in a one-read, one-write synchronous memory with read-first behaviour. The output side is a single elastic stage with one valid bit. The memory's registered read port is that stage's data register. A wrapping slot counter moves forward on each output transfer. Its next value addresses the memory, so the slot that is read and the slot that is overwritten in the same accepting cycle are the same one. The first `DELAY_P` output transfers after reset carry whatever the memory held; they may be flagged valid, and their data is undefined.

Top module: `dlybuf_top`

## Requirements
- R1: A synchronous reset drives valid_o to 0 and the slot counter to 0, so that ready_o is 1 in the first cycle after reset.
- R2: ready_o is 1 exactly when valid_o is 0 or ready_i is 1. An input transfer happens when valid_i and ready_o are both 1; an output transfer happens when valid_o and ready_i are both 1.
- R3: After a cycle with an input transfer, valid_o is 1. After a cycle with an output transfer and no input transfer, valid_o is 0.
- R4: While valid_o is 1 and ready_i is 0, valid_o and data_o hold their values into the next cycle.
- R5: Number input transfers from 0 after reset. The item taken at input transfer k is presented on data_o at output transfer k + DELAY_P. Output transfers 0 to DELAY_P-1 carry undefined data.
- R6: The pairing in R5 holds under any pattern of input bubbles and output back-pressure. It does not depend on how many items are stored.
- R7: The slot counter counts 0 up to DELAY_P-1 and then wraps to 0, one step per output transfer. The pairing in R5 keeps holding over many wraps.
- R8: In a cycle with valid_i at 0, data_i is ignored and no item is consumed. Once the stage has drained, valid_o stays 0 until the next input transfer.
- R9: A reset in the middle of a stream restarts the numbering in R5 from 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Upstream has an item on data_i |
| data_i | input | WIDTH_P | Incoming item |
| ready_o | output | 1 | Block can take an item this cycle |
| valid_o | output | 1 | data_o holds an item for downstream |
| data_o | output | WIDTH_P | Outgoing item, read from the slot memory |
| ready_i | input | 1 | Downstream takes data_o this cycle |

## Verification
Suppose the slot counter skips a step, wraps early or advances on the wrong transfer. The read and write slots then drift apart, and the first output transfer that pairs with a real item shows a value from the wrong handshake. This shows up within one trip around the buffer, which is at most DELAY_P output transfers. A valid bit that loses or invents an item breaks the one-in, one-out count. The scoreboard then pops too few or too many entries, and every later comparison is shifted. A data register that moves during back-pressure is caught in the very next stalled cycle.

// File: rtl/dlybuf_pkg.sv
package dlybuf_pkg;

  // Slot that follows cur in a ring whose highest index is last.
  function automatic int unsigned slot_after(input int unsigned cur,
                                             input int unsigned last);
    if (cur >= last) return 0;
    return cur + 1;
  endfunction

  // An elastic stage has room when it is empty or is being emptied.
  function automatic logic room_for_input(input logic stage_full,
                                          input logic taker_ready);
    return !stage_full || taker_ready;
  endfunction

endpackage

// File: rtl/dlybuf_wrap_ctr.sv
module dlybuf_wrap_ctr #(
  parameter int AW   = 3,
  parameter int LAST = 4
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          step_i,
  output logic [AW-1:0] cnt_q_o,
  output logic [AW-1:0] cnt_nxt_o
);

  logic [AW-1:0] cnt_q;
  logic [AW-1:0] wrapped;

  // Mealy next value: the memory sees the updated address in the same cycle.
  assign wrapped   = AW'(dlybuf_pkg::slot_after(32'(cnt_q), 32'(LAST)));
  assign cnt_nxt_o = step_i ? wrapped : cnt_q;
  assign cnt_q_o   = cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) cnt_q <= '0;
    else       cnt_q <= cnt_nxt_o;
  end

endmodule

// File: rtl/dlybuf_ram_rf.sv
module dlybuf_ram_rf #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 5,
  parameter int AW    = 3
) (
  input  logic             clk_i,
  input  logic             rd_en_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [WIDTH-1:0] rd_data_o,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [WIDTH-1:0] wr_data_i
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rd_q;

  // Read-first: a read and a write to one slot in one cycle return the old word.
  always_ff @(posedge clk_i) begin
    if (rd_en_i) rd_q <= mem[rd_addr_i];
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = rd_q;

endmodule

// File: rtl/dlybuf_elastic_ctl.sv
module dlybuf_elastic_ctl (
  input  logic clk_i,
  input  logic rst_i,
  input  logic up_valid_i,
  output logic up_ready_o,
  output logic dn_valid_o,
  input  logic dn_ready_i,
  output logic take_o,
  output logic give_o
);

  logic full_q;

  assign up_ready_o = dlybuf_pkg::room_for_input(full_q, dn_ready_i);
  assign take_o     = up_valid_i && up_ready_o;
  assign give_o     = full_q && dn_ready_i;
  assign dn_valid_o = full_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)       full_q <= 1'b0;
    else if (take_o) full_q <= 1'b1;
    else if (give_o) full_q <= 1'b0;
  end

endmodule

// File: rtl/dlybuf_top.sv
module dlybuf_top #(
  parameter int WIDTH_P = 16,
  parameter int DELAY_P = 5
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               valid_i,
  input  logic [WIDTH_P-1:0] data_i,
  output logic               ready_o,
  output logic               valid_o,
  output logic [WIDTH_P-1:0] data_o,
  input  logic               ready_i
);

  localparam int AW   = (DELAY_P > 1) ? $clog2(DELAY_P) : 1;
  localparam int LAST = DELAY_P - 1;

  // Named internal events, shared with the bound checker.
  logic          in_fire;
  logic          out_fire;
  logic [AW-1:0] slot_q;
  logic [AW-1:0] slot_nxt;

  dlybuf_elastic_ctl u_ctl (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .up_valid_i (valid_i),
    .up_ready_o (ready_o),
    .dn_valid_o (valid_o),
    .dn_ready_i (ready_i),
    .take_o     (in_fire),
    .give_o     (out_fire)
  );

  dlybuf_wrap_ctr #(
    .AW   (AW),
    .LAST (LAST)
  ) u_ctr (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .step_i    (out_fire),
    .cnt_q_o   (slot_q),
    .cnt_nxt_o (slot_nxt)
  );

  // Accepted inputs = output transfers + valid bit, so the slot of the item
  // taken now is the counter's next value.
  dlybuf_ram_rf #(
    .WIDTH (WIDTH_P),
    .DEPTH (DELAY_P),
    .AW    (AW)
  ) u_ram (
    .clk_i     (clk_i),
    .rd_en_i   (in_fire),
    .rd_addr_i (slot_nxt),
    .rd_data_o (data_o),
    .wr_en_i   (in_fire),
    .wr_addr_i (slot_nxt),
    .wr_data_i (data_i)
  );

endmodule

// File: rtl/dlybuf_checks.sv
module dlybuf_checks #(
  parameter int WIDTH_P = 16,
  parameter int DELAY_P = 5,
  parameter int AW      = 3
) (
  input logic               clk_i,
  input logic               rst_i,
  input logic               ready_o,
  input logic               valid_o,
  input logic [WIDTH_P-1:0] data_o,
  input logic               ready_i,
  input logic               in_fire,
  input logic               out_fire,
  input logic [AW-1:0]      slot_q
);

  localparam logic [AW-1:0] LAST = AW'(DELAY_P - 1);

  a_r1_reset_clears: assert property (@(posedge clk_i)
    rst_i |=> (!valid_o && slot_q == '0))
    else $error("R1 reset did not clear state");

  a_r2_empty_has_room: assert property (@(posedge clk_i) disable iff (rst_i)
    !valid_o |-> ready_o)
    else $error("R2 empty stage refused input");

  a_r2_full_needs_drain: assert property (@(posedge clk_i) disable iff (rst_i)
    (in_fire && valid_o) |-> out_fire)
    else $error("R2 input taken into a full stage");

  a_r3_fill: assert property (@(posedge clk_i) disable iff (rst_i)
    in_fire |=> valid_o)
    else $error("R3 valid not set after accept");

  a_r3_drain: assert property (@(posedge clk_i) disable iff (rst_i)
    (out_fire && !in_fire) |=> !valid_o)
    else $error("R3 valid not cleared after drain");

  a_r4_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o)))
    else $error("R4 output moved under back-pressure");

  a_r7_range: assert property (@(posedge clk_i) disable iff (rst_i)
    slot_q <= LAST)
    else $error("R7 slot out of range");

  a_r7_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
    (out_fire && slot_q == LAST) |=> slot_q == '0)
    else $error("R7 slot did not wrap");

  a_r7_step: assert property (@(posedge clk_i) disable iff (rst_i)
    (out_fire && slot_q != LAST) |=> slot_q == AW'($past(slot_q) + 1'b1))
    else $error("R7 slot did not step");

  a_r7_idle: assert property (@(posedge clk_i) disable iff (rst_i)
    !out_fire |=> $stable(slot_q))
    else $error("R7 slot moved without output transfer");

endmodule

bind dlybuf_top dlybuf_checks #(
  .WIDTH_P (WIDTH_P),
  .DELAY_P (DELAY_P),
  .AW      (AW)
) u_checks (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .ready_o  (ready_o),
  .valid_o  (valid_o),
  .data_o   (data_o),
  .ready_i  (ready_i),
  .in_fire  (in_fire),
  .out_fire (out_fire),
  .slot_q   (slot_q)
);

// File: tb/tb_dlybuf_top.sv
`timescale 1ns/1ps
module tb_dlybuf_top;

  localparam int W = 16;
  localparam int D = 5;

  logic         clk = 1'b0;
  logic         rst_i = 1'b1;
  logic         valid_i = 1'b0;
  logic [W-1:0] data_i = '0;
  logic         ready_i = 1'b0;
  logic         ready_o;
  logic         valid_o;
  logic [W-1:0] data_o;

  always #2.5 clk = ~clk;

  dlybuf_top #(.WIDTH_P(W), .DELAY_P(D)) dut (
    .clk_i   (clk),
    .rst_i   (rst_i),
    .valid_i (valid_i),
    .data_i  (data_i),
    .ready_o (ready_o),
    .valid_o (valid_o),
    .data_o  (data_o),
    .ready_i (ready_i)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Scoreboard entries: bit W marks a value that must match.
  logic [W:0] exp_q [$];

  logic         p_hold, p_in, p_out;
  logic [W-1:0] p_dout;
  logic [15:0]  lfsr = 16'hACE1;
  logic [W-1:0] seq = 16'h1000;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic refill();
    exp_q.delete();
    for (int i = 0; i < D; i++) exp_q.push_back('0);
    p_hold = 0; p_in = 0; p_out = 0; p_dout = '0;
  endtask

  task automatic drv_push(input logic [W-1:0] d);
    exp_q.push_back({1'b1, d});
  endtask

  task automatic mon_pop(input string tag, input logic [W-1:0] dout);
    logic [W:0] e;
    if (exp_q.size() == 0) begin
      chk(0, tag, "output transfer with no pending item", 32'(dout), 0);
    end else begin
      e = exp_q.pop_front();
      if (e[W]) chk(dout == e[W-1:0], tag, "paired item", 32'(dout), 32'(e[W-1:0]));
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic cycle(input logic v, input logic [W-1:0] d, input logic r,
                       input string tag);
    logic rdy, vo, in_f, out_f;
    logic [W-1:0] dout;
    @(negedge clk);
    valid_i = v; data_i = d; ready_i = r;
    #1;
    rdy = ready_o; vo = valid_o; dout = data_o;
    chk(rdy == (!vo || r), "R2", "ready_o", 32'(rdy), 32'(!vo || r));
    if (p_hold) begin
      chk(vo == 1'b1, "R4", "valid under stall", 32'(vo), 1);
      chk(dout == p_dout, "R4", "data under stall", 32'(dout), 32'(p_dout));
    end else if (p_in) begin
      chk(vo == 1'b1, "R3", "valid after accept", 32'(vo), 1);
    end else if (p_out) begin
      chk(vo == 1'b0, "R3", "valid after drain", 32'(vo), 0);
    end
    in_f  = v && rdy;
    out_f = vo && r;
    if (out_f) mon_pop(tag, dout);
    if (in_f)  drv_push(d);
    p_hold = vo && !r; p_in = in_f; p_out = out_f; p_dout = dout;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_i = 1'b1; valid_i = 1'b0; ready_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_i = 1'b0;
    #1;
    chk(valid_o == 1'b0, "R1", "valid_o after reset", 32'(valid_o), 0);
    chk(ready_o == 1'b1, "R1", "ready_o after reset", 32'(ready_o), 1);
    refill();
  endtask

  initial begin
    do_reset();

    // Full throughput.
    for (int i = 0; i < 40; i++) begin
      seq = seq + 16'd3;
      cycle(1'b1, seq, 1'b1, "R5");
    end

    // Random bubbles and back-pressure.
    for (int i = 0; i < 120; i++) begin
      step_lfsr(); seq = seq + 16'd7;
      cycle(lfsr[0], seq ^ lfsr, lfsr[3] | lfsr[5], "R6");
    end

    // Long stall with input offered.
    for (int i = 0; i < 6; i++) begin
      seq = seq + 16'd1;
      cycle(1'b1, seq, 1'b0, "R6");
    end
    for (int i = 0; i < 10; i++) begin
      seq = seq + 16'd1;
      cycle(1'b1, seq, 1'b1, "R6");
    end

    // Idle with junk on data_i: nothing consumed, stage drains.
    for (int i = 0; i < 10; i++) begin
      step_lfsr();
      cycle(1'b0, lfsr, 1'b1, "R8");
      if (i >= 2) chk(valid_o == 1'b0, "R8", "valid_o while idle", 32'(valid_o), 0);
    end

    // Many wraps, mixed traffic.
    for (int i = 0; i < 300; i++) begin
      step_lfsr(); seq = seq + 16'd11;
      cycle(lfsr[1] | lfsr[4], seq, lfsr[2] | lfsr[7] | lfsr[9], "R7");
    end

    // Reset in the middle of a stream.
    for (int i = 0; i < 7; i++) begin
      seq = seq + 16'd5;
      cycle(1'b1, seq, 1'b1, "R9");
    end
    do_reset();
    for (int i = 0; i < 60; i++) begin
      step_lfsr(); seq = seq + 16'd13;
      cycle(lfsr[6] | lfsr[0], seq, lfsr[8] | lfsr[11], "R9");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL R5 watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule